// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves a small processor core between four operating states: full-speed run, idle, clock-stopped stop, and shutdown with the regulator powered down. Software requests a state by writing a power-control field. The move takes effect only when the core signals that the writing instruction has completed. A separate regulator-configuration bit decides whether a stop request ends in plain stop or continues on into shutdown.

Each low-power state has its own set of wake sources. Idle wakes on any enabled interrupt request and resumes without a reset. Stop wakes only on an internal or external reset. Shutdown wakes only on the external pin reset or on power-on reset. Every reset exit returns the core to run with the request bits cleared and holds a core reset request for a fixed number of cycles. The block drives the CPU clock enable, the peripheral clock enable, the oscillator enable and the regulator enable, and it reports the current state as a 2-bit code.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `mode` reports run=0, idle=1, stop=2, shutdown=3. The enables `cpuClkEn`, `periphClkEn`, `oscEn` and `regEn` are 1,1,1,1 in run, 0,1,1,1 in idle, 0,0,0,1 in stop and 0,0,0,0 in shutdown.
- R2: While `porRstN` is low the block is in run. After `porRstN` is released, `coreRstReq` stays high for exactly RST_CYCLES cycles (default 4) and then falls.
- R3: A write with `wrSel`=0 loads the idle request from `wrData[0]` and the stop request from `wrData[1]`. A write with `wrSel`=1 loads the regulator-configuration bit from `wrData[0]`. Writes are accepted only in run. A set request changes no state until an `instrDone` strobe arrives, and a write in the same cycle as `instrDone` already counts. The new state is visible one cycle after that edge.
- R4: If the idle and stop requests are both set when `instrDone` arrives, the block enters stop.
- R5: In idle, any set bit of `irqPend` returns the block to run on the next edge without a core reset. The idle request is also cleared, so a later `instrDone` does not re-enter idle.
- R6: In stop, `irqPend` has no effect. `intRst` or `pinRst` exits stop through a reset sequence.
- R7: If the stop request is taken while the regulator-configuration bit is 1, the block shows stop for one cycle and then shutdown, where `regEn` is 0. If that bit is 0, the block stays in stop.
- R8: In shutdown, `intRst` and `irqPend` have no effect and `coreRstReq` stays low. `pinRst` exits shutdown through a reset sequence.
- R9: An accepted `pinRst` or `intRst`, in run, idle or stop, returns the block to run on the next edge with both request bits cleared. `coreRstReq` is then high for exactly RST_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| pinRst | input | 1 | External pin reset, active high, sampled on the clock |
| intRst | input | 1 | Internal reset source, active high |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the power-control field, 1 selects the regulator-configuration bit |
| wrData | input | 2 | Write data |
| instrDone | input | 1 | Strobe marking that the current instruction has completed |
| irqPend | input | NUM_IRQ | Enabled interrupt requests |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| regEn | output | 1 | Regulator enable |
| coreRstReq | output | 1 | Reset request to the core |
| mode | output | 2 | Current state code |

## Verification
Every state change and every reset request is registered. A stimulus applied before a rising edge therefore shows at the outputs right after that edge. The one exception is the shutdown step, which appears one edge after stop is shown. The bench changes inputs at the falling edge, lets exactly one rising edge pass, and samples at the next falling edge. For shutdown it waits one more falling edge before sampling. Reset request lengths are measured by counting successive falling edges on which `coreRstReq` is high, starting with the first sample after the accepting edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_STOP = 2'd2,
    MODE_SHUT = 2'd3
  } pwrMode_e;

  // strobes from the sequencer to the register/counter datapath
  typedef struct packed {
    logic wrOk;     // register writes allowed (core running)
    logic clrIdle;  // interrupt wake: drop the idle request
    logic rstSeq;   // accepted reset: clear requests, start reset pulse
  } ctlStrobe_t;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       instrDone,
  input  logic       irqAny,
  input  logic       intRst,
  input  logic       pinRst,
  input  logic       effIdle,
  input  logic       effStop,
  input  logic       effRegCfg,
  output pwrMode_e   modeQ,
  output ctlStrobe_t strb
);

  pwrMode_e modeD;
  logic     shutPendQ, shutPendD;
  logic     rstTaken;

  // shutdown honours only the pin reset; other states take either source
  assign rstTaken = (modeQ == MODE_SHUT) ? pinRst : (pinRst | intRst);

  always_comb begin
    modeD        = modeQ;
    shutPendD    = shutPendQ;
    strb         = '0;
    strb.wrOk    = (modeQ == MODE_RUN);
    if (rstTaken) begin
      modeD       = MODE_RUN;
      shutPendD   = 1'b0;
      strb.rstSeq = 1'b1;
    end else begin
      unique case (modeQ)
        MODE_RUN: begin
          if (instrDone && effStop) begin
            modeD     = MODE_STOP;
            shutPendD = effRegCfg;
          end else if (instrDone && effIdle) begin
            modeD = MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (irqAny) begin
            modeD        = MODE_RUN;
            strb.clrIdle = 1'b1;
          end
        end
        MODE_STOP: begin
          if (shutPendQ) modeD = MODE_SHUT;
        end
        MODE_SHUT: modeD = MODE_SHUT;
        default:   modeD = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      modeQ     <= MODE_RUN;
      shutPendQ <= 1'b0;
    end else begin
      modeQ     <= modeD;
      shutPendQ <= shutPendD;
    end
  end

endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [1:0] wrData,
  input  ctlStrobe_t strb,
  input  pwrMode_e   modeQ,
  output logic       effIdle,
  output logic       effStop,
  output logic       effRegCfg,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn,
  output logic       regEn,
  output logic       coreRstReq
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_CYCLES);

  logic             idleQ, stopQ, regCfgQ;
  logic [CNT_W-1:0] rstCntQ;
  logic             wrCtrl, wrCfg;

  assign wrCtrl = wrEn && strb.wrOk && !wrSel;
  assign wrCfg  = wrEn && strb.wrOk &&  wrSel;

  // same-cycle write is visible to the entry decision
  assign effIdle   = wrCtrl ? wrData[0] : idleQ;
  assign effStop   = wrCtrl ? wrData[1] : stopQ;
  assign effRegCfg = wrCfg  ? wrData[0] : regCfgQ;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      idleQ   <= 1'b0;
      stopQ   <= 1'b0;
      regCfgQ <= 1'b0;
      rstCntQ <= CNT_INIT;
    end else begin
      if (strb.rstSeq) begin
        idleQ <= 1'b0;
        stopQ <= 1'b0;
      end else if (strb.clrIdle) begin
        idleQ <= 1'b0;
      end else if (wrCtrl) begin
        idleQ <= wrData[0];
        stopQ <= wrData[1];
      end
      if (wrCfg) regCfgQ <= wrData[0];
      if (strb.rstSeq)        rstCntQ <= CNT_INIT;
      else if (rstCntQ != '0) rstCntQ <= rstCntQ - 1'b1;
    end
  end

  assign coreRstReq = (rstCntQ != '0);

  always_comb begin
    unique case (modeQ)
      MODE_RUN:  {cpuClkEn, periphClkEn, oscEn, regEn} = 4'b1111;
      MODE_IDLE: {cpuClkEn, periphClkEn, oscEn, regEn} = 4'b0111;
      MODE_STOP: {cpuClkEn, periphClkEn, oscEn, regEn} = 4'b0001;
      default:   {cpuClkEn, periphClkEn, oscEn, regEn} = 4'b0000;
    endcase
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_IRQ    = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               pinRst,
  input  logic               intRst,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [1:0]         wrData,
  input  logic               instrDone,
  input  logic [NUM_IRQ-1:0] irqPend,
  output logic               cpuClkEn,
  output logic               periphClkEn,
  output logic               oscEn,
  output logic               regEn,
  output logic               coreRstReq,
  output logic [1:0]         mode
);

  pwrMode_e   modeQ;
  ctlStrobe_t strb;
  logic       effIdle, effStop, effRegCfg;

  pwr_mode_fsm fsm_i (
    .clk       (clk),
    .porRstN   (porRstN),
    .instrDone (instrDone),
    .irqAny    (|irqPend),
    .intRst    (intRst),
    .pinRst    (pinRst),
    .effIdle   (effIdle),
    .effStop   (effStop),
    .effRegCfg (effRegCfg),
    .modeQ     (modeQ),
    .strb      (strb)
  );

  pwr_mode_dp #(.RST_CYCLES(RST_CYCLES)) dp_i (
    .clk         (clk),
    .porRstN     (porRstN),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .wrData      (wrData),
    .strb        (strb),
    .modeQ       (modeQ),
    .effIdle     (effIdle),
    .effStop     (effStop),
    .effRegCfg   (effRegCfg),
    .cpuClkEn    (cpuClkEn),
    .periphClkEn (periphClkEn),
    .oscEn       (oscEn),
    .regEn       (regEn),
    .coreRstReq  (coreRstReq)
  );

  assign mode = modeQ;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NUM_IRQ = 4
) (
  input logic               clk,
  input logic               porRstN,
  input logic               pinRst,
  input logic               intRst,
  input logic [NUM_IRQ-1:0] irqPend,
  input logic               regEn,
  input logic               coreRstReq,
  input logic [1:0]         mode
);

  assert_idle_irq_wake_R5: assert property (@(posedge clk) disable iff (!porRstN)
    (mode == 2'd1 && (|irqPend) && !intRst && !pinRst) |=> (mode == 2'd0 && !coreRstReq));

  assert_stop_no_irq_exit_R6: assert property (@(posedge clk) disable iff (!porRstN)
    (mode == 2'd2 && !intRst && !pinRst) |=> (mode != 2'd0));

  assert_shut_after_stop_R7: assert property (@(posedge clk) disable iff (!porRstN)
    (mode == 2'd3 && $past(mode) != 2'd3) |-> ($past(mode) == 2'd2));

  assert_shut_holds_R8: assert property (@(posedge clk) disable iff (!porRstN)
    (mode == 2'd3 && !pinRst) |=> (mode == 2'd3 && !regEn));

  assert_reset_exit_R9: assert property (@(posedge clk) disable iff (!porRstN)
    (pinRst || (intRst && mode != 2'd3)) |=> (mode == 2'd0 && coreRstReq));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk        (clk),
  .porRstN    (porRstN),
  .pinRst     (pinRst),
  .intRst     (intRst),
  .irqPend    (irqPend),
  .regEn      (regEn),
  .coreRstReq (coreRstReq),
  .mode       (mode)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NIRQ       = 4;
  localparam int RSTLEN     = 4;

  logic            clk = 1'b0;
  logic            porRstN = 1'b0;
  logic            pinRst = 1'b0, intRst = 1'b0;
  logic            wrEn = 1'b0, wrSel = 1'b0;
  logic [1:0]      wrData = 2'b00;
  logic            instrDone = 1'b0;
  logic [NIRQ-1:0] irqPend = '0;
  logic            cpuClkEn, periphClkEn, oscEn, regEn, coreRstReq;
  logic [1:0]      mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NIRQ), .RST_CYCLES(RSTLEN)) dut_i (
    .clk(clk), .porRstN(porRstN), .pinRst(pinRst), .intRst(intRst),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .instrDone(instrDone),
    .irqPend(irqPend), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .oscEn(oscEn), .regEn(regEn), .coreRstReq(coreRstReq), .mode(mode)
  );

  task automatic chkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkEn(string req, logic [3:0] exp);
    chkVal(req, "enables cpu/per/osc/reg", int'({cpuClkEn, periphClkEn, oscEn, regEn}), int'(exp));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doWrite(logic sel, logic [1:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    tick();
    wrEn = 1'b0; wrData = 2'b00;
  endtask

  task automatic pulseDone();
    instrDone = 1'b1; tick(); instrDone = 1'b0;
  endtask

  task automatic checkRstPulse(string req);
    int cnt = 0;
    while (coreRstReq && cnt < 20) begin
      cnt++;
      tick();
    end
    chkVal(req, "coreRstReq length", cnt, RSTLEN);
    chkVal(req, "mode after reset", int'(mode), 0);
  endtask

  task automatic testPor();
    chkVal("R2", "mode at release", int'(mode), 0);
    chkEn("R1", 4'b1111);
    checkRstPulse("R2");
  endtask

  task automatic testIdle();
    doWrite(1'b0, 2'b01);
    chkVal("R3", "no entry before instrDone", int'(mode), 0);
    pulseDone();
    chkVal("R3", "idle entry", int'(mode), 1);
    chkEn("R1", 4'b0111);
    doWrite(1'b0, 2'b10);              // ignored: core halted
    chkVal("R3", "write in idle no effect", int'(mode), 1);
    irqPend = 4'b0100; tick(); irqPend = '0;
    chkVal("R5", "irq wake", int'(mode), 0);
    chkVal("R5", "no reset on wake", int'(coreRstReq), 0);
    pulseDone();
    chkVal("R5", "idle bit cleared, stop write dropped", int'(mode), 0);
  endtask

  task automatic testSameCycleAndPin();
    wrEn = 1'b1; wrSel = 1'b0; wrData = 2'b01; instrDone = 1'b1;
    tick();
    wrEn = 1'b0; wrData = 2'b00; instrDone = 1'b0;
    chkVal("R3", "same-cycle write entry", int'(mode), 1);
    pinRst = 1'b1; tick(); pinRst = 1'b0;
    chkVal("R9", "pin reset from idle", int'(mode), 0);
    checkRstPulse("R9");
    pulseDone();
    chkVal("R9", "requests cleared", int'(mode), 0);
  endtask

  task automatic testStop();
    doWrite(1'b1, 2'b00);
    wrEn = 1'b1; wrSel = 1'b0; wrData = 2'b11; instrDone = 1'b1;
    tick();
    wrEn = 1'b0; wrData = 2'b00; instrDone = 1'b0;
    chkVal("R4", "stop wins over idle", int'(mode), 2);
    chkEn("R1", 4'b0001);
    tick();
    chkVal("R7", "no shutdown with cfg clear", int'(mode), 2);
    irqPend = 4'b1111; tick(); irqPend = '0;
    chkVal("R6", "irq ignored in stop", int'(mode), 2);
    intRst = 1'b1; tick(); intRst = 1'b0;
    chkVal("R6", "internal reset exits stop", int'(mode), 0);
    checkRstPulse("R6");
  endtask

  task automatic testShutdown();
    doWrite(1'b1, 2'b01);
    doWrite(1'b0, 2'b10);
    chkVal("R3", "stop pending without instrDone", int'(mode), 0);
    pulseDone();
    chkVal("R7", "stop shown first", int'(mode), 2);
    chkVal("R7", "regulator still on", int'(regEn), 1);
    tick();
    chkVal("R7", "shutdown reached", int'(mode), 3);
    chkEn("R1", 4'b0000);
    intRst = 1'b1; tick(); intRst = 1'b0;
    chkVal("R8", "internal reset ignored", int'(mode), 3);
    chkVal("R8", "no core reset", int'(coreRstReq), 0);
    irqPend = 4'b0001; tick(); irqPend = '0;
    chkVal("R8", "irq ignored", int'(mode), 3);
    pinRst = 1'b1; tick(); pinRst = 1'b0;
    chkVal("R8", "pin reset exits shutdown", int'(mode), 0);
    checkRstPulse("R8");
  endtask

  task automatic testRunReset();
    intRst = 1'b1; tick(); intRst = 1'b0;
    chkVal("R9", "run reset mode", int'(mode), 0);
    checkRstPulse("R9");
  endtask

  task automatic testPorInShutdown();
    doWrite(1'b0, 2'b10);             // regulator cfg still set
    pulseDone();
    tick();
    chkVal("R7", "shutdown again", int'(mode), 3);
    porRstN = 1'b0;
    #1;
    chkVal("R2", "power-on reset forces run", int'(mode), 0);
    tick();
    porRstN = 1'b1;
    checkRstPulse("R2");
  endtask

  initial begin
    repeat (3) tick();
    porRstN = 1'b1;
    testPor();
    testIdle();
    testSameCycleAndPin();
    testStop();
    testShutdown();
    testRunReset();
    testPorInShutdown();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule